// File: doc/BRIEF.md
# PWM Buffered Register Reload Scheduler

This block decides when the buffered copies of the PWM compare values and control fields are moved into the active copies that a PWM generator reads. Software writes the buffered copies through a simple register port and then sets a load-permit flag. The block watches the free-running submodule counter for two kinds of reload opportunity. A half-cycle opportunity occurs when the counter reaches the VAL0 input, and a full-cycle opportunity occurs when it reaches the VAL1 input. Each kind has its own enable. The block counts enabled opportunities against a programmable load frequency.

When the count reaches the programmed frequency, the current load cycle is complete. At that point a frequency value written since the last completion takes effect, whether or not the load-permit flag is set. If the flag is set, the buffered values are also copied into the active registers, the flag is cleared and a one-cycle load strobe is issued. In immediate mode, a set load-permit flag causes the copy on the next clock and does not wait for an opportunity.

Top module: `pwm_reload_sched`

## Requirements
- R1: After reset, the load strobe is low, every active compare value and the active divider field are 0, and all register reads return 0. The active and buffered load frequency are therefore 0, which makes every opportunity a load point.
- R2: An opportunity is counted once, on the first cycle in which the counter equals its reference value. For a half-cycle opportunity the reference is VAL0 and the half enable (control bit 4) must be set. For a full-cycle opportunity the reference is VAL1 and the full enable (control bit 5) must be set. An opportunity whose enable is clear is not counted.
- R3: With an active load-frequency value N, a load cycle completes on every (N+1)th counted opportunity.
- R4: With both enables set, half-cycle and full-cycle opportunities are counted together in one count, so one PWM period gives two opportunities.
- R5: While both enables and immediate mode (control bit 6) are clear, no transfer happens, even with the load-permit flag set, and the flag stays set.
- R6: When a load cycle completes with the load-permit flag clear, nothing is transferred, no strobe is issued, and the opportunity count restarts from zero.
- R7: A newly written load-frequency value becomes active only when the load cycle in progress completes, whether or not the load-permit flag is set.
- R8: Reading the control register returns the buffered load frequency in bits [3:0], together with the other written control fields, even when the active frequency differs.
- R9: In immediate mode, once the load-permit flag is set, the buffered values are transferred on the next clock, and the flag then reads 0.
- R10: A transfer updates the active registers and raises the load strobe for exactly one cycle, the same cycle in which the new active values appear. A transfer also clears the load-permit flag.
- R11: The opportunity count is held at zero while both enables are clear.
- R12: The register map is as follows. Address 0 is control: bits [3:0] frequency, bit 4 half enable, bit 5 full enable, bit 6 immediate mode, bits [10:8] divider field, other bits read 0. Address 1 is the load-permit flag in bit 0: writing 1 sets it and writing 0 has no effect. Address 2+i holds buffered compare value i. The active divider field is transferred together with the compare values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | DATA_W | Register write data |
| rdAddr | input | ADDR_W | Register read address |
| rdData | output | DATA_W | Register read data (combinational) |
| cnt | input | CNT_W | Submodule counter value |
| val0 | input | CNT_W | Half-cycle reference value |
| val1 | input | CNT_W | Full-cycle reference value |
| loadStrobe | output | 1 | One-cycle pulse on each transfer |
| actDiv | output | DIV_W | Active divider field |
| actCmp | output | NUM_CMP*CNT_W | Active compare values, entry i at bits [i*CNT_W +: CNT_W] |

## Verification
The bench builds the block with CNT_W=8, NUM_CMP=3 and DATA_W=16, which gives a 3-bit address space. Each counter match can then be forced with a single counter value: 0x40 for half-cycle opportunities, 0x80 for full-cycle opportunities, and 0xFF as an idle value that matches neither. Three compare entries are enough to show that the compare values are transferred independently of one another, and the full 4-bit frequency field remains available. The bench uses frequency values 0, 1 and 2 to make each frequency change occur in the middle of a load cycle, with the load-permit flag both set and clear.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;
  // register addresses
  localparam int CTRL_ADDR = 0;
  localparam int OK_ADDR   = 1;
  localparam int CMP_BASE  = 2;
  // control register field positions
  localparam int FREQ_LSB  = 0;
  localparam int HALF_BIT  = 4;
  localparam int FULL_BIT  = 5;
  localparam int IMM_BIT   = 6;
  localparam int DIV_LSB   = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic transfer;   // copy buffered -> active, clear load permit
    logic cycleDone;  // load cycle complete, adopt buffered frequency
  } loadCmd_t;
endpackage

// File: rtl/pwm_opp_detect.sv
module pwm_opp_detect #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] refVal,
  output logic             opp
);
  logic match;
  logic matchPrev;

  assign match = (cnt == refVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchPrev <= 1'b0;
    else       matchPrev <= match;
  end

  // first cycle of a match only, gated by its enable
  assign opp = en && match && !matchPrev;

  a_r2_opp_first_cycle: assert property (@(posedge clk) disable iff (!rstN)
    opp |=> !opp);
endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
  import pwm_reload_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FREQ_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  val0,
  input  logic [CNT_W-1:0]  val1,
  input  logic              halfEn,
  input  logic              fullEn,
  input  logic              immMode,
  input  logic              loadOk,
  input  logic [FREQ_W-1:0] actFreq,
  output loadCmd_t          cmd,
  output logic              loadStrobe
);
  localparam int N_SRC = 2;  // 0: half-cycle, 1: full-cycle

  logic [N_SRC-1:0] srcEn;
  logic [N_SRC-1:0] srcOpp;
  logic [CNT_W-1:0] srcRef [N_SRC];

  assign srcEn[0]  = halfEn;
  assign srcEn[1]  = fullEn;
  assign srcRef[0] = val0;
  assign srcRef[1] = val1;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    pwm_opp_detect #(.CNT_W(CNT_W)) u_det (
      .clk    (clk),
      .rstN   (rstN),
      .en     (srcEn[s]),
      .cnt    (cnt),
      .refVal (srcRef[s]),
      .opp    (srcOpp[s])
    );
  end

  logic              anyOpp;
  logic              bothOff;
  logic [FREQ_W-1:0] oppCnt;
  logic              cycleDone;
  logic              doTransfer;

  assign anyOpp     = |srcOpp;
  assign bothOff    = !halfEn && !fullEn;
  assign cycleDone  = anyOpp && (oppCnt == actFreq);
  assign doTransfer = loadOk && (cycleDone || immMode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oppCnt <= '0;
    end else if (bothOff || cycleDone) begin
      oppCnt <= '0;
    end else if (anyOpp) begin
      oppCnt <= oppCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loadStrobe <= 1'b0;
    else       loadStrobe <= doTransfer;
  end

  assign cmd.transfer  = doTransfer;
  assign cmd.cycleDone = cycleDone;

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    oppCnt <= actFreq);
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    bothOff |=> (oppCnt == '0));
  a_r5_strobe_source: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> ($past(loadOk) && ($past(immMode) || $past(anyOpp))));
  a_r9_imm_load: assert property (@(posedge clk) disable iff (!rstN)
    (immMode && loadOk) |=> loadStrobe);
endmodule

// File: rtl/pwm_reload_dp.sv
module pwm_reload_dp
  import pwm_reload_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 4,
  parameter int DATA_W  = 16,
  parameter int FREQ_W  = 4,
  parameter int DIV_W   = 3,
  parameter int ADDR_W  = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [ADDR_W-1:0]        rdAddr,
  output logic [DATA_W-1:0]        rdData,
  input  loadCmd_t                 cmd,
  output logic                     halfEn,
  output logic                     fullEn,
  output logic                     immMode,
  output logic                     loadOk,
  output logic [FREQ_W-1:0]        actFreq,
  output logic [DIV_W-1:0]         actDiv,
  output logic [NUM_CMP*CNT_W-1:0] actCmp
);
  localparam int CMP_KEEP = (CNT_W < DATA_W) ? CNT_W : DATA_W;

  logic [FREQ_W-1:0] bufFreq;
  logic [DIV_W-1:0]  bufDiv;
  logic [CNT_W-1:0]  bufCmp [NUM_CMP];
  logic              ctrlWr;
  logic              okSet;

  assign ctrlWr = wrEn && (wrAddr == ADDR_W'(CTRL_ADDR));
  assign okSet  = wrEn && (wrAddr == ADDR_W'(OK_ADDR)) && wrData[0];

  // control register: enables are direct, frequency and divider buffered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufFreq <= '0;
      bufDiv  <= '0;
      halfEn  <= 1'b0;
      fullEn  <= 1'b0;
      immMode <= 1'b0;
    end else if (ctrlWr) begin
      bufFreq <= wrData[FREQ_LSB +: FREQ_W];
      bufDiv  <= wrData[DIV_LSB +: DIV_W];
      halfEn  <= wrData[HALF_BIT];
      fullEn  <= wrData[FULL_BIT];
      immMode <= wrData[IMM_BIT];
    end
  end

  // load permit: a new set request wins over the clear of a transfer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             loadOk <= 1'b0;
    else if (okSet)        loadOk <= 1'b1;
    else if (cmd.transfer) loadOk <= 1'b0;
  end

  // frequency follows the load cycle, never the permit flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              actFreq <= '0;
    else if (cmd.cycleDone) actFreq <= bufFreq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             actDiv <= '0;
    else if (cmd.transfer) actDiv <= bufDiv;
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    logic cmpWr;
    assign cmpWr = wrEn && (wrAddr == ADDR_W'(CMP_BASE + i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      bufCmp[i] <= '0;
      else if (cmpWr) bufCmp[i] <= CNT_W'(wrData[CMP_KEEP-1:0]);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             actCmp[i*CNT_W +: CNT_W] <= '0;
      else if (cmd.transfer) actCmp[i*CNT_W +: CNT_W] <= bufCmp[i];
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(CTRL_ADDR)) begin
      rdData[FREQ_LSB +: FREQ_W] = bufFreq;
      rdData[DIV_LSB +: DIV_W]   = bufDiv;
      rdData[HALF_BIT]           = halfEn;
      rdData[FULL_BIT]           = fullEn;
      rdData[IMM_BIT]            = immMode;
    end else if (rdAddr == ADDR_W'(OK_ADDR)) begin
      rdData[0] = loadOk;
    end else begin
      for (int i = 0; i < NUM_CMP; i++) begin
        if (rdAddr == ADDR_W'(CMP_BASE + i)) rdData[CMP_KEEP-1:0] = bufCmp[i][CMP_KEEP-1:0];
      end
    end
  end

  a_r10_ok_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.transfer && !okSet) |=> !loadOk);
  a_r10_active_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.transfer |=> ($stable(actCmp) && $stable(actDiv)));
  a_r7_freq_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.cycleDone |=> $stable(actFreq));
endmodule

// File: rtl/pwm_reload_sched.sv
module pwm_reload_sched
  import pwm_reload_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 4,
  parameter int DATA_W  = 16,
  parameter int FREQ_W  = 4,
  parameter int DIV_W   = 3,
  localparam int ADDR_W = $clog2(NUM_CMP + CMP_BASE)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [ADDR_W-1:0]        rdAddr,
  output logic [DATA_W-1:0]        rdData,
  input  logic [CNT_W-1:0]         cnt,
  input  logic [CNT_W-1:0]         val0,
  input  logic [CNT_W-1:0]         val1,
  output logic                     loadStrobe,
  output logic [DIV_W-1:0]         actDiv,
  output logic [NUM_CMP*CNT_W-1:0] actCmp
);
  loadCmd_t          cmd;
  logic              halfEn;
  logic              fullEn;
  logic              immMode;
  logic              loadOk;
  logic [FREQ_W-1:0] actFreq;

  pwm_reload_dp #(
    .CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .DATA_W(DATA_W),
    .FREQ_W(FREQ_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .cmd     (cmd),
    .halfEn  (halfEn),
    .fullEn  (fullEn),
    .immMode (immMode),
    .loadOk  (loadOk),
    .actFreq (actFreq),
    .actDiv  (actDiv),
    .actCmp  (actCmp)
  );

  pwm_reload_ctrl #(.CNT_W(CNT_W), .FREQ_W(FREQ_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cnt        (cnt),
    .val0       (val0),
    .val1       (val1),
    .halfEn     (halfEn),
    .fullEn     (fullEn),
    .immMode    (immMode),
    .loadOk     (loadOk),
    .actFreq    (actFreq),
    .cmd        (cmd),
    .loadStrobe (loadStrobe)
  );
endmodule

// File: tb/pwm_reload_sched_bench.sv
module pwm_reload_sched_bench;
  localparam int PERIOD  = 10;
  localparam int CNT_W   = 8;
  localparam int NUM_CMP = 3;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 3;
  localparam logic [7:0] V0   = 8'h40;
  localparam logic [7:0] V1   = 8'h80;
  localparam logic [7:0] IDLE = 8'hFF;

  // vector: {setOk, isFull, wrCmp[7:0], expStrobe, expCmp0[7:0]}
  localparam int NVEC = 8;
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'h11, 1'b1, 8'h11},  // freq 0 active: completes, loads
    {1'b0, 1'b1, 8'h00, 1'b0, 8'h11},  // count 1 (freq 2 now active)
    {1'b0, 1'b0, 8'h00, 1'b0, 8'h11},  // count 2
    {1'b0, 1'b1, 8'h00, 1'b0, 8'h11},  // completes without permit
    {1'b1, 1'b0, 8'h22, 1'b0, 8'h11},  // count 1
    {1'b0, 1'b1, 8'h00, 1'b0, 8'h11},  // count 2
    {1'b0, 1'b0, 8'h00, 1'b1, 8'h22},  // completes, loads
    {1'b0, 1'b1, 8'h00, 1'b0, 8'h22}
  };

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic                     wrEn = 1'b0;
  logic [ADDR_W-1:0]        wrAddr = '0;
  logic [DATA_W-1:0]        wrData = '0;
  logic [ADDR_W-1:0]        rdAddr = '0;
  logic [DATA_W-1:0]        rdData;
  logic [CNT_W-1:0]         cnt = IDLE;
  logic [CNT_W-1:0]         val0 = V0;
  logic [CNT_W-1:0]         val1 = V1;
  logic                     loadStrobe;
  logic [2:0]               actDiv;
  logic [NUM_CMP*CNT_W-1:0] actCmp;

  int checks = 0;
  int failures = 0;

  always #(PERIOD/2) clk = ~clk;

  pwm_reload_sched #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .DATA_W(DATA_W)) u_pwm_reload_sched (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cnt(cnt), .val0(val0), .val1(val1),
    .loadStrobe(loadStrobe), .actDiv(actDiv), .actCmp(actCmp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic pulse(input logic [7:0] v, output logic s1, output logic s2);
    cnt = v;
    @(negedge clk);
    s1 = loadStrobe;
    cnt = IDLE;
    @(negedge clk);
    s2 = loadStrobe;
  endtask

  initial begin
    #(PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] d;
    logic s1, s2;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 strobe", loadStrobe, 0);
    chk("R1 actCmp", actCmp, 0);
    chk("R1 actDiv", actDiv, 0);
    rd(0, d); chk("R1 ctrl read", d, 0);
    rd(1, d); chk("R1 permit read", d, 0);
    rd(2, d); chk("R1 cmp read", d, 0);

    // R5 no enables, no immediate: nothing moves; R12 write-0 to permit ignored
    wr(0, 16'h0000);
    wr(2, 16'h0033);
    wr(1, 16'h0001);
    wr(1, 16'h0000);
    rd(1, d); chk("R12 permit write 0 ignored", d, 1);
    pulse(V0, s1, s2); chk("R5 half no strobe", s1, 0);
    pulse(V1, s1, s2); chk("R5 full no strobe", s1, 0);
    chk("R5 actCmp unchanged", actCmp, 0);
    rd(1, d); chk("R5 permit kept", d, 1);
    rd(2, d); chk("R12 cmp0 buffered read", d, 16'h0033);

    // table: freq 2, both enables, divider 3 (R3 R4 R6 R10)
    wr(0, 16'h0332);
    for (int i = 0; i < NVEC; i++) begin
      logic [18:0] v;
      v = VEC[i];
      if (v[18]) begin
        wr(2, {8'h00, v[16:9]});
        wr(1, 16'h0001);
      end
      pulse(v[17] ? V1 : V0, s1, s2);
      chk($sformatf("R3/R4/R6 strobe vec %0d", i), s1, v[8]);
      chk($sformatf("R10 strobe one cycle vec %0d", i), s2, 0);
      chk($sformatf("R10 actCmp0 vec %0d", i), actCmp[7:0], v[7:0]);
    end
    chk("R12 actDiv transferred", actDiv, 3);
    rd(1, d); chk("R10 permit cleared", d, 0);

    // R7 / R8: switch to freq 0, half only, count currently 1 of 2
    wr(0, 16'h0310);
    rd(0, d); chk("R8 buffered freq read", d, 16'h0310);
    wr(1, 16'h0001);
    pulse(V1, s1, s2); chk("R2 disabled full ignored", s1, 0);
    pulse(V0, s1, s2); chk("R7 old freq still counting", s1, 0);
    pulse(V0, s1, s2); chk("R7 cycle completes", s1, 1);
    wr(1, 16'h0001);
    pulse(V0, s1, s2); chk("R3 freq 0 every opportunity", s1, 1);

    // R7 change adopted on a completion without permit
    wr(0, 16'h0311);
    pulse(V0, s1, s2); chk("R7 completion w/o permit", s1, 0);
    wr(1, 16'h0001);
    pulse(V0, s1, s2); chk("R7 new freq 1 first opp", s1, 0);
    pulse(V0, s1, s2); chk("R7 new freq 1 second opp", s1, 1);

    // R11 count held at zero while disabled
    pulse(V0, s1, s2); chk("R11 count to 1", s1, 0);
    wr(0, 16'h0301);
    @(negedge clk);
    wr(0, 16'h0311);
    wr(1, 16'h0001);
    pulse(V0, s1, s2); chk("R11 restart from zero", s1, 0);
    pulse(V0, s1, s2); chk("R11 load after restart", s1, 1);

    // R9 immediate mode
    wr(0, 16'h0541);
    wr(3, 16'h005A);
    wr(1, 16'h0001);
    chk("R9 no strobe before next clock", loadStrobe, 0);
    @(negedge clk);
    chk("R9 strobe", loadStrobe, 1);
    chk("R9 actCmp1", actCmp[15:8], 8'h5A);
    chk("R9 actDiv", actDiv, 5);
    rd(1, d); chk("R9 permit cleared", d, 0);
    @(negedge clk);
    chk("R10 immediate strobe one cycle", loadStrobe, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule